// File: doc/BRIEF.md
# Paged Circular Data Address Generator

This block turns a small bank of 16-bit index pointers into 24-bit data memory addresses. Each pointer owns a base and a length that together define a circular buffer which may start at any address. Four modify registers provide step sizes, and an 8-bit page register supplies the upper address bits. An access request picks a pointer, a step source (modify register or signed 8-bit immediate) and an addressing mode. The block replies one cycle later with the address and the pointer value after the operation.

Two complete register sets exist: primary and secondary. A single select line chooses which set is read, written and updated, so a task switch costs no register saves. Register writes and access requests may arrive in the same cycle. A write to an index pointer overrides that pointer's own update.

Top module: `circ_dag`

## Requirements
- R1: While reset is held and after it is released, every pointer, modify, base, length and page register of both sets reads zero, and `out_valid` and `addr_valid` stay low in any cycle after a cycle with `req_en` low.
- R2: Post-modify by register (mode 0) outputs the current index as the low address bits, then writes back the stepped index. It raises `out_valid` and `addr_valid` one cycle after the request.
- R3: Pre-modify by register (mode 1) outputs the stepped index and leaves the pointer unchanged. Repeated identical pre-modify requests give the same address.
- R4: In modes 2 (post) and 3 (pre), `req_imm` is sign-extended from 8 bits and used in place of the modify register.
- R5: Modify-only (mode 4) adds the sign-extended `req_imm` to the pointer. It raises `out_valid` with `addr_valid` low. Modes 6 and 7 do nothing and raise neither flag.
- R6: With a nonzero length, a stepped index at or above base+length has the length subtracted, and one below base has the length added. A zero length gives a plain 16-bit wrapping add. The base needs no alignment.
- R7: `addr` is {page, low 16 bits}. Index arithmetic never carries into the page bits.
- R8: Bit-reverse (mode 5) outputs all 16 bits of the pre-update index in reversed order, and still applies the register post-modify update.
- R9: `bank_sel` = 0 selects the primary set and 1 the secondary set for reads, writes and updates. The other set is left untouched.
- R10: If an index write and an update hit the same pointer in one cycle, the written value is kept.
- R11: `wr_kind` selects the target of a write: 0 index, 1 modify, 2 base, 3 length, 4 page (low 8 bits of `wr_data`). Codes 5 to 7 change nothing. `wr_sel` picks the pointer or modify slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_sel | input | 1 | Register set select: 0 primary, 1 secondary |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 3 | Write target kind |
| wr_sel | input | 2 | Pointer or modify slot for the write |
| wr_data | input | 16 | Write data |
| req_en | input | 1 | Operation request |
| req_mode | input | 3 | Addressing mode |
| req_ptr | input | 2 | Pointer used by the request |
| req_mod_sel | input | 2 | Modify register used by the request |
| req_imm | input | 8 | Signed immediate step |
| out_valid | output | 1 | An operation completed last cycle |
| addr_valid | output | 1 | `addr` carries a memory address |
| addr | output | 24 | Page and low address |
| upd_index | output | 16 | Pointer value after the operation |

## Verification
The hardest case to reach is a circular wrap that must be taken in both directions while the base is unaligned. A further difficulty is the case where the wrap bound base+length lies beyond 16 bits, so that only the low 16 bits of the sum land back inside the page. The stimulus loads odd bases with short lengths and steps the pointer across both ends with positive modify values and negative immediates. It also places a buffer against the top of the page. A long random phase then keeps lengths small, so wraps, bank swaps and write/update collisions all occur often against the behavioural model.

// File: rtl/cag_pkg.sv
package cag_pkg;

    typedef enum logic [2:0] {
        AM_POST_REG = 3'd0,
        AM_PRE_REG  = 3'd1,
        AM_POST_IMM = 3'd2,
        AM_PRE_IMM  = 3'd3,
        AM_MODIFY   = 3'd4,
        AM_BITREV   = 3'd5,
        AM_NOP6     = 3'd6,
        AM_NOP7     = 3'd7
    } access_mode_e;

    typedef enum logic [2:0] {
        RK_INDEX  = 3'd0,
        RK_MODIFY = 3'd1,
        RK_BASE   = 3'd2,
        RK_LENGTH = 3'd3,
        RK_PAGE   = 3'd4,
        RK_RSV5   = 3'd5,
        RK_RSV6   = 3'd6,
        RK_RSV7   = 3'd7
    } reg_kind_e;

endpackage

// File: rtl/cag_regfile.sv
module cag_regfile
    import cag_pkg::*;
#(
    parameter int NPTR   = 4,
    parameter int IDX_W  = 16,
    parameter int PAGE_W = 8,
    localparam int PSEL_W = $clog2(NPTR),
    localparam int NBANK  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bank_sel,
    input  logic                          wr_en,
    input  reg_kind_e                     wr_kind,
    input  logic [PSEL_W-1:0]             wr_sel,
    input  logic [IDX_W-1:0]              wr_data,
    input  logic                          upd_en,
    input  logic [PSEL_W-1:0]             upd_ptr,
    input  logic [IDX_W-1:0]              upd_val,
    output logic [NPTR-1:0][IDX_W-1:0]    idx_o,
    output logic [NPTR-1:0][IDX_W-1:0]    mdf_o,
    output logic [NPTR-1:0][IDX_W-1:0]    base_o,
    output logic [NPTR-1:0][IDX_W-1:0]    len_o,
    output logic [PAGE_W-1:0]             page_o
);

    logic [NBANK-1:0][NPTR-1:0][IDX_W-1:0] idx_all;
    logic [NBANK-1:0][NPTR-1:0][IDX_W-1:0] mdf_all;
    logic [NBANK-1:0][NPTR-1:0][IDX_W-1:0] base_all;
    logic [NBANK-1:0][NPTR-1:0][IDX_W-1:0] len_all;
    logic [NBANK-1:0][PAGE_W-1:0]          page_all;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic bank_hit;
        logic [PAGE_W-1:0] page_r;
        assign bank_hit = (bank_sel == 1'(b));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                page_r <= '0;
            end else if (bank_hit && wr_en && wr_kind == RK_PAGE) begin
                page_r <= wr_data[PAGE_W-1:0];
            end
        end
        assign page_all[b] = page_r;

        for (genvar p = 0; p < NPTR; p++) begin : g_ptr
            logic [IDX_W-1:0] idx_r, mdf_r, base_r, len_r;
            logic             wr_hit;
            assign wr_hit = bank_hit && wr_en && (wr_sel == PSEL_W'(p));

            // index: update first, a same-cycle write overrides it
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    idx_r <= '0;
                end else begin
                    if (bank_hit && upd_en && upd_ptr == PSEL_W'(p)) begin
                        idx_r <= upd_val;
                    end
                    if (wr_hit && wr_kind == RK_INDEX) begin
                        idx_r <= wr_data;
                    end
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mdf_r  <= '0;
                    base_r <= '0;
                    len_r  <= '0;
                end else if (wr_hit) begin
                    case (wr_kind)
                        RK_MODIFY: mdf_r  <= wr_data;
                        RK_BASE:   base_r <= wr_data;
                        RK_LENGTH: len_r  <= wr_data;
                        default:   ;
                    endcase
                end
            end

            assign idx_all[b][p]  = idx_r;
            assign mdf_all[b][p]  = mdf_r;
            assign base_all[b][p] = base_r;
            assign len_all[b][p]  = len_r;
        end
    end

    assign idx_o  = idx_all[bank_sel];
    assign mdf_o  = mdf_all[bank_sel];
    assign base_o = base_all[bank_sel];
    assign len_o  = len_all[bank_sel];
    assign page_o = page_all[bank_sel];

endmodule

// File: rtl/cag_modulo.sv
module cag_modulo #(
    parameter int IDX_W = 16,
    localparam int EXT_W = IDX_W + 4
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] step,
    input  logic [IDX_W-1:0] base,
    input  logic [IDX_W-1:0] len,
    output logic [IDX_W-1:0] result
);

    logic signed [EXT_W-1:0] sum_x, top_x, bot_x, len_x, fix_x;

    always_comb begin
        len_x = $signed({4'b0000, len});
        bot_x = $signed({4'b0000, base});
        top_x = bot_x + len_x;
        sum_x = $signed({4'b0000, idx}) + $signed({{4{step[IDX_W-1]}}, step});
        fix_x = sum_x;
        if (len != '0) begin
            if (sum_x >= top_x) begin
                fix_x = sum_x - len_x;
            end else if (sum_x < bot_x) begin
                fix_x = sum_x + len_x;
            end
        end
        result = fix_x[IDX_W-1:0];
    end

endmodule

// File: rtl/cag_bitrev.sv
module cag_bitrev #(
    parameter int IDX_W = 16
) (
    input  logic [IDX_W-1:0] din,
    output logic [IDX_W-1:0] dout
);

    for (genvar i = 0; i < IDX_W; i++) begin : g_bit
        assign dout[i] = din[IDX_W-1-i];
    end

endmodule

// File: rtl/circ_dag.sv
module circ_dag
    import cag_pkg::*;
#(
    parameter int NPTR   = 4,
    parameter int IDX_W  = 16,
    parameter int PAGE_W = 8,
    parameter int IMM_W  = 8,
    localparam int PSEL_W = $clog2(NPTR),
    localparam int ADDR_W = PAGE_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_sel,
    input  logic              wr_en,
    input  logic [2:0]        wr_kind,
    input  logic [PSEL_W-1:0] wr_sel,
    input  logic [IDX_W-1:0]  wr_data,
    input  logic              req_en,
    input  logic [2:0]        req_mode,
    input  logic [PSEL_W-1:0] req_ptr,
    input  logic [PSEL_W-1:0] req_mod_sel,
    input  logic [IMM_W-1:0]  req_imm,
    output logic              out_valid,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  upd_index
);

    logic [NPTR-1:0][IDX_W-1:0] idx_v, mdf_v, base_v, len_v;
    logic [PAGE_W-1:0]          page_v;

    access_mode_e     mode;
    logic             use_imm, do_upd, do_acc, pick_pre, pick_rev, known;
    logic [IDX_W-1:0] cur_idx, step, next_idx, rev_idx, low_addr, imm_ext;

    assign mode    = access_mode_e'(req_mode);
    assign cur_idx = idx_v[req_ptr];
    assign imm_ext = {{(IDX_W-IMM_W){req_imm[IMM_W-1]}}, req_imm};

    always_comb begin
        use_imm  = 1'b0;
        do_upd   = 1'b0;
        do_acc   = 1'b0;
        pick_pre = 1'b0;
        pick_rev = 1'b0;
        known    = 1'b1;
        unique case (mode)
            AM_POST_REG: begin do_upd = 1'b1; do_acc = 1'b1; end
            AM_PRE_REG:  begin do_acc = 1'b1; pick_pre = 1'b1; end
            AM_POST_IMM: begin use_imm = 1'b1; do_upd = 1'b1; do_acc = 1'b1; end
            AM_PRE_IMM:  begin use_imm = 1'b1; do_acc = 1'b1; pick_pre = 1'b1; end
            AM_MODIFY:   begin use_imm = 1'b1; do_upd = 1'b1; end
            AM_BITREV:   begin do_upd = 1'b1; do_acc = 1'b1; pick_rev = 1'b1; end
            default:     known = 1'b0;
        endcase
    end

    assign step = use_imm ? imm_ext : mdf_v[req_mod_sel];

    cag_regfile #(.NPTR(NPTR), .IDX_W(IDX_W), .PAGE_W(PAGE_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .bank_sel(bank_sel),
        .wr_en   (wr_en),
        .wr_kind (reg_kind_e'(wr_kind)),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .upd_en  (req_en && do_upd),
        .upd_ptr (req_ptr),
        .upd_val (next_idx),
        .idx_o   (idx_v),
        .mdf_o   (mdf_v),
        .base_o  (base_v),
        .len_o   (len_v),
        .page_o  (page_v)
    );

    cag_modulo #(.IDX_W(IDX_W)) u_mod (
        .idx   (cur_idx),
        .step  (step),
        .base  (base_v[req_ptr]),
        .len   (len_v[req_ptr]),
        .result(next_idx)
    );

    cag_bitrev #(.IDX_W(IDX_W)) u_rev (
        .din (cur_idx),
        .dout(rev_idx)
    );

    assign low_addr = pick_rev ? rev_idx : (pick_pre ? next_idx : cur_idx);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            addr_valid <= 1'b0;
            addr       <= '0;
            upd_index  <= '0;
        end else begin
            out_valid  <= req_en && known;
            addr_valid <= req_en && do_acc;
            if (req_en && known) begin
                addr      <= {page_v, low_addr};
                upd_index <= do_upd ? next_idx : cur_idx;
            end
        end
    end

endmodule

// File: rtl/circ_dag_chk.sv
module circ_dag_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        bank_sel,
    input logic        req_en,
    input logic [2:0]  req_mode,
    input logic [1:0]  req_ptr,
    input logic [1:0]  req_mod_sel,
    input logic        out_valid,
    input logic        addr_valid,
    input logic [23:0] addr
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_en |=> (!out_valid && !addr_valid));

    // R2
    post_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_en && req_mode == 3'd0) |=> (out_valid && addr_valid));

    // R5
    modify_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_en && req_mode == 3'd4) |=> (out_valid && !addr_valid));

    // R5
    reserved_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_en && req_mode[2:1] == 2'b11) |=> !out_valid);

    // R3
    pre_repeat_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_en && req_mode == 3'd1 && !$past(wr_en) && $past(req_en)
         && $past(req_mode) == 3'd1 && $past(req_ptr) == req_ptr
         && $past(req_mod_sel) == req_mod_sel && $past(bank_sel) == bank_sel)
        |=> $stable(addr));

endmodule

bind circ_dag circ_dag_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .bank_sel   (bank_sel),
    .req_en     (req_en),
    .req_mode   (req_mode),
    .req_ptr    (req_ptr),
    .req_mod_sel(req_mod_sel),
    .out_valid  (out_valid),
    .addr_valid (addr_valid),
    .addr       (addr)
);

// File: tb/circ_dag_test.sv
module circ_dag_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bank_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_kind = '0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        req_en = 1'b0;
    logic [2:0]  req_mode = '0;
    logic [1:0]  req_ptr = '0;
    logic [1:0]  req_mod_sel = '0;
    logic [7:0]  req_imm = '0;
    logic        out_valid, addr_valid;
    logic [23:0] addr;
    logic [15:0] upd_index;

    always #10 clk = ~clk;

    circ_dag uut (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .wr_en(wr_en),
        .wr_kind(wr_kind), .wr_sel(wr_sel), .wr_data(wr_data),
        .req_en(req_en), .req_mode(req_mode), .req_ptr(req_ptr),
        .req_mod_sel(req_mod_sel), .req_imm(req_imm),
        .out_valid(out_valid), .addr_valid(addr_valid),
        .addr(addr), .upd_index(upd_index)
    );

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // behavioural model state
    int m_idx [2][4];
    int m_mdf [2][4];
    int m_base[2][4];
    int m_len [2][4];
    int m_pg  [2];

    bit    e_pend = 1'b0;
    int    e_ov, e_av, e_addr, e_upd;
    string e_tag;

    task automatic check(string tag, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int s16(int v);
        return (v >= 32768) ? v - 65536 : v;
    endfunction

    function automatic int s8(int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    function automatic int rev16(int v);
        int r = 0;
        for (int i = 0; i < 16; i++) if (v[i]) r = r | (1 << (15 - i));
        return r;
    endfunction

    task automatic compare_prev();
        if (!e_pend) return;
        check(e_tag, "out_valid", int'(out_valid), e_ov);
        check(e_tag, "addr_valid", int'(addr_valid), e_av);
        if (e_av != 0) check(e_tag, "addr", int'(addr), e_addr);
        if (e_ov != 0) check(e_tag, "upd_index", int'(upd_index), e_upd);
    endtask

    // one clock: check the previous result, then drive and predict
    task automatic step(bit b, bit we, int wk, int ws, int wd,
                        bit re, int md, int pt, int ms, int im, string tag);
        int i_cur, off, n, lo, hi, a_low;
        bit wb;
        @(negedge clk);
        compare_prev();
        bank_sel = b; wr_en = we; wr_kind = 3'(wk); wr_sel = 2'(ws); wr_data = 16'(wd);
        req_en = re; req_mode = 3'(md); req_ptr = 2'(pt); req_mod_sel = 2'(ms); req_imm = 8'(im);
        i_cur = m_idx[b][pt];
        off = (md == 2 || md == 3 || md == 4) ? s8(im) : s16(m_mdf[b][ms]);
        n  = i_cur + off;
        lo = m_base[b][pt];
        hi = lo + m_len[b][pt];
        if (m_len[b][pt] != 0) begin
            if (n >= hi) n = n - m_len[b][pt];
            else if (n < lo) n = n + m_len[b][pt];
        end
        n = n & 16'hFFFF;
        wb = 1'b0; a_low = i_cur;
        case (md)
            0, 2: begin a_low = i_cur; e_upd = n; wb = 1'b1; end
            1, 3: begin a_low = n; e_upd = i_cur; end
            4:    begin e_upd = n; wb = 1'b1; end
            5:    begin a_low = rev16(i_cur); e_upd = n; wb = 1'b1; end
            default: e_upd = 0;
        endcase
        e_ov = (re && md <= 5) ? 1 : 0;
        e_av = (re && md <= 5 && md != 4) ? 1 : 0;
        e_addr = (m_pg[b] << 16) | a_low;
        e_tag = tag;
        e_pend = 1'b1;
        if (re && wb) m_idx[b][pt] = n;
        if (we) begin
            case (wk)
                0: m_idx[b][ws]  = wd & 16'hFFFF;
                1: m_mdf[b][ws]  = wd & 16'hFFFF;
                2: m_base[b][ws] = wd & 16'hFFFF;
                3: m_len[b][ws]  = wd & 16'hFFFF;
                4: m_pg[b]       = wd & 8'hFF;
                default: ;
            endcase
        end
    endtask

    task automatic wr(bit b, int wk, int ws, int wd, string tag);
        step(b, 1'b1, wk, ws, wd, 1'b0, 0, 0, 0, 0, tag);
    endtask

    task automatic rq(bit b, int md, int pt, int ms, int im, string tag);
        step(b, 1'b0, 0, 0, 0, 1'b1, md, pt, ms, im, tag);
    endtask

    initial begin
        for (int b = 0; b < 2; b++) begin
            m_pg[b] = 0;
            for (int p = 0; p < 4; p++) begin
                m_idx[b][p] = 0; m_mdf[b][p] = 0; m_base[b][p] = 0; m_len[b][p] = 0;
            end
        end
        repeat (3) @(negedge clk);
        // R1: outputs held low in reset
        check("R1", "out_valid", int'(out_valid), 0);
        check("R1", "addr_valid", int'(addr_valid), 0);
        check("R1", "addr", int'(addr), 0);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
        rq(0, 0, 0, 0, 0, "R1");
        rq(1, 0, 3, 2, 0, "R1");

        // R11 / R2 setup and post-modify by register
        wr(0, 0, 0, 16'h1000, "R11");
        wr(0, 1, 1, 3, "R11");
        wr(0, 4, 0, 16'hAB12, "R11");
        wr(0, 5, 0, 16'h7777, "R11");
        rq(0, 0, 0, 1, 0, "R2");
        rq(0, 0, 0, 1, 0, "R2");
        // R3: pre-modify, repeated
        rq(0, 1, 0, 1, 0, "R3");
        rq(0, 1, 0, 1, 0, "R3");
        rq(0, 0, 0, 0, 0, "R3");
        // R4: immediates, negative and positive
        rq(0, 2, 0, 0, 8'hFB, "R4");
        rq(0, 3, 0, 0, 8'h7F, "R4");
        rq(0, 3, 0, 0, 8'h80, "R4");
        rq(0, 0, 0, 0, 0, "R4");
        // R5: modify only and reserved modes
        rq(0, 4, 0, 0, 8'h10, "R5");
        rq(0, 6, 0, 1, 8'h10, "R5");
        rq(0, 7, 0, 1, 8'h10, "R5");
        rq(0, 0, 0, 0, 0, "R5");
        // R6: circular buffer at unaligned base 0x0103 length 10
        wr(0, 2, 1, 16'h0103, "R6");
        wr(0, 3, 1, 10, "R6");
        wr(0, 0, 1, 16'h010B, "R6");
        wr(0, 1, 2, 4, "R6");
        rq(0, 0, 1, 2, 0, "R6");
        rq(0, 0, 1, 2, 0, "R6");
        rq(0, 2, 1, 0, 8'hFC, "R6");
        rq(0, 2, 1, 0, 8'hFC, "R6");
        rq(0, 2, 1, 0, 8'hFC, "R6");
        rq(0, 1, 1, 2, 0, "R6");
        // R7: linear wrap at top of page, no carry into page
        wr(0, 0, 2, 16'hFFFE, "R7");
        wr(0, 1, 0, 5, "R7");
        rq(0, 0, 2, 0, 0, "R7");
        rq(0, 0, 2, 0, 0, "R7");
        wr(0, 2, 2, 16'hFFF0, "R7");
        wr(0, 3, 2, 16'h0020, "R7");
        wr(0, 0, 2, 16'hFFFC, "R7");
        rq(0, 0, 2, 0, 0, "R7");
        rq(0, 0, 2, 0, 0, "R7");
        // R8: bit reverse
        wr(0, 0, 3, 16'h0001, "R8");
        rq(0, 5, 3, 1, 0, "R8");
        rq(0, 5, 3, 1, 0, "R8");
        rq(0, 0, 3, 0, 0, "R8");
        // R9: secondary set independent
        rq(1, 0, 0, 1, 0, "R9");
        wr(1, 0, 0, 16'h2222, "R9");
        wr(1, 4, 0, 16'h0055, "R9");
        rq(1, 0, 0, 0, 0, "R9");
        rq(0, 0, 0, 0, 0, "R9");
        // R10: write beats update on the same pointer
        step(0, 1'b1, 0, 0, 16'h4444, 1'b1, 0, 0, 1, 0, "R10");
        rq(0, 0, 0, 0, 0, "R10");
        step(0, 1'b1, 0, 1, 16'h0105, 1'b1, 4, 1, 0, 8'h01, "R10");
        rq(0, 0, 1, 0, 0, "R10");

        // mixed random traffic with short buffers
        for (int k = 0; k < 600; k++) begin
            int wk, wd;
            wk = $urandom_range(0, 7);
            wd = $urandom_range(0, 65535);
            if (wk == 3) wd = $urandom_range(0, 24);
            if (wk == 1) wd = $urandom_range(0, 1) ? $urandom_range(0, 12) : 65536 - $urandom_range(1, 12);
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0), wk,
                 $urandom_range(0, 3), wd, 1'($urandom_range(0, 4) != 0),
                 $urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 3),
                 $urandom_range(0, 255), "R6");
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
        @(negedge clk);
        compare_prev();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule